// File: doc/BRIEF.md
# Packet Monitor Register Bank

This block is a 32-bit AXI4-Lite slave that gives host software a small window into a packet-processing stage. It returns a fixed identifier and a version word, and it keeps two packet tallies. One counts packets entering the stage and the other counts packets leaving it. The stage itself reports each packet as a one-cycle pulse.

It also offers three scratch locations. One stores the written word but returns its bitwise inverse. One is a plain read/write word. The third keeps its contents internally in reversed byte order, so what comes back over the bus matches what went in. Reading a tally returns it and empties it, which lets software poll rates without doing arithmetic. A software-reset pulse returns every register to its default without touching the bus handshake state.

Top module: `pktmon_regbank`

## Requirements
- R1: The word at offset 0x00 always reads 0x0000DA03. Writes to it complete with OKAY and change nothing.
- R2: The word at offset 0x04 always reads 0x00000001. Writes to it are ignored.
- R3: Offset 0x08 stores written bytes under the byte strobes and reads back the bitwise complement of the stored word. It therefore reads 0xFFFFFFFF after reset.
- R4: Offset 0x0C tallies `pkt_in_pulse` and offset 0x10 tallies `pkt_out_pulse`, one count per high cycle. The count sits in bits CNT_W-1:0 (31 bits by default), the overflow flag in bit 31, and the bits in between read zero. Bus writes to either offset leave the tally unchanged.
- R5: A read that is accepted on the read-address channel returns the tally as it stood before that clock edge. The count and the flag are then zero. A pulse arriving in the same cycle as that read is lost, because the clear wins.
- R6: When the count wraps from all ones to zero, bit 31 sets. It stays set through further pulses until a read clears it.
- R7: Offset 0x14 is a plain read/write word. Each strobe bit WSTRB[i] enables bus byte lane i (data bits 8i+7:8i).
- R8: Offset 0x18 reads back exactly what was written to it in bus byte order, with the strobes applied per bus lane, even though it is stored byte-reversed.
- R9: A one-cycle `sw_reset` pulse returns R3, R4, R7 and R8 state to their reset values: flip stored 0, tallies and flags 0, debug 0, big-endian word 0.
- R10: Write address and write data may be accepted in either order or together. BVALID rises only after both have been accepted, carries BRESP = 00, and stays high until BREADY.
- R11: RVALID stays high and RDATA stays stable until RREADY. RRESP is 00. Reads of unmapped offsets (0x1C and above) return 0, and writes to them have no effect.
- R12: After `rst`, BVALID and RVALID are low and AWREADY, WREADY and ARREADY are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | One-cycle pulse that restores register defaults |
| pkt_in_pulse | input | 1 | One-cycle pulse per incoming packet |
| pkt_out_pulse | input | 1 | One-cycle pulse per outgoing packet |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
Some properties are checked on every cycle. Response valids hold until they are taken, and read data stays stable while it waits. A clear empties a tally no matter what pulse arrives with it. The overflow flag stays set and sets on a wrap. A software reset zeroes the scratch words, and the identifier returns its constant. Other behaviour only the bench scenarios can show. These are the complemented flip readback, strobe lanes surviving the byte reversal, the loss of a pulse that coincides with a clearing read, and writes completing in each arrival order. They are compared against a behavioural model with a reduced counter width, so that wrap is reachable.

// File: rtl/pktmon_pkg.sv
package pktmon_pkg;
  localparam logic [31:0] ID_VALUE      = 32'h0000_DA03;
  localparam logic [31:0] VERSION_VALUE = 32'h0000_0001;

  localparam int SLOT_ID      = 0;
  localparam int SLOT_VER     = 1;
  localparam int SLOT_FLIP    = 2;
  localparam int SLOT_CNT_IN  = 3;
  localparam int SLOT_CNT_OUT = 4;
  localparam int SLOT_DBG     = 5;
  localparam int SLOT_BE      = 6;
  localparam int NUM_TALLY    = 2;

  function automatic logic [31:0] byte_rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [3:0] strb_rev(input logic [3:0] s);
    return {s[0], s[1], s[2], s[3]};
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  strb);
    logic [31:0] r;
    r = old_v;
    for (int i = 0; i < 4; i++)
      if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pkt_counter.sv
module pkt_counter #(
  parameter int CNT_W = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        inc,
  output logic [31:0] value
);
  logic [CNT_W-1:0] count_q;
  logic             ovf_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (inc) begin
      count_q <= count_q + 1'b1;
      if (&count_q) ovf_q <= 1'b1;
    end
  end

  generate
    if (CNT_W == 31) begin : g_full
      assign value = {ovf_q, count_q};
    end else begin : g_pad
      assign value = {ovf_q, {(31-CNT_W){1'b0}}, count_q};
    end
  endgenerate

  // R5
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_q == '0 && !ovf_q));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);
  // R6
  ovf_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && (&count_q)) |=> ovf_q);
  // R4
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(count_q));
endmodule

// File: rtl/axil_wr_port.sv
module axil_wr_port #(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb
);
  logic aw_full, w_full;

  assign awready = !aw_full;
  assign wready  = !w_full;
  assign wr_en   = aw_full && w_full && !bvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      bvalid  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (awvalid && !aw_full) begin
        aw_full <= 1'b1;
        wr_idx  <= awaddr[ADDR_W-1:2];
      end
      if (wvalid && !w_full) begin
        w_full  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
      if (wr_en) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid  <= 1'b0;
      end
    end
  end

  // R10
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);
  // R10
  b_after_both_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bvalid) |-> $past(aw_full && w_full));
endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port #(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              rd_fire,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [31:0]       rd_value
);
  assign arready = !rvalid;
  assign rd_fire = arvalid && !rvalid;
  assign rd_idx  = araddr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_fire) begin
      rvalid <= 1'b1;
      rdata  <= rd_value;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  // R11
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

// File: rtl/pktmon_regbank.sv
module pktmon_regbank
  import pktmon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 31,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_reset,
  input  logic              pkt_in_pulse,
  input  logic              pkt_out_pulse,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  logic             reg_rst;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_data;
  logic [3:0]       wr_strb;
  logic             rd_fire;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      rd_value;
  logic [31:0]      flip_q, dbg_q, be_q;
  logic [NUM_TALLY-1:0] pulse, clr;
  logic [31:0]      tally [NUM_TALLY];

  assign reg_rst = rst || sw_reset;
  assign s_bresp = 2'b00;
  assign s_rresp = 2'b00;

  axil_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  axil_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .rd_fire(rd_fire), .rd_idx(rd_idx), .rd_value(rd_value)
  );

  assign pulse[0] = pkt_in_pulse;
  assign pulse[1] = pkt_out_pulse;
  assign clr[0]   = rd_fire && (rd_idx == IDX_W'(SLOT_CNT_IN));
  assign clr[1]   = rd_fire && (rd_idx == IDX_W'(SLOT_CNT_OUT));

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tally
    pkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(reg_rst), .clr(clr[g]), .inc(pulse[g]), .value(tally[g])
    );
  end

  always_ff @(posedge clk) begin
    if (reg_rst) begin
      flip_q <= '0;
      dbg_q  <= '0;
      be_q   <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(SLOT_FLIP)) flip_q <= lane_merge(flip_q, wr_data, wr_strb);
      if (wr_idx == IDX_W'(SLOT_DBG))  dbg_q  <= lane_merge(dbg_q, wr_data, wr_strb);
      if (wr_idx == IDX_W'(SLOT_BE))
        be_q <= lane_merge(be_q, byte_rev(wr_data), strb_rev(wr_strb));
    end
  end

  always_comb begin
    rd_value = '0;
    if      (rd_idx == IDX_W'(SLOT_ID))      rd_value = ID_VALUE;
    else if (rd_idx == IDX_W'(SLOT_VER))     rd_value = VERSION_VALUE;
    else if (rd_idx == IDX_W'(SLOT_FLIP))    rd_value = ~flip_q;
    else if (rd_idx == IDX_W'(SLOT_CNT_IN))  rd_value = tally[0];
    else if (rd_idx == IDX_W'(SLOT_CNT_OUT)) rd_value = tally[1];
    else if (rd_idx == IDX_W'(SLOT_DBG))     rd_value = dbg_q;
    else if (rd_idx == IDX_W'(SLOT_BE))      rd_value = byte_rev(be_q);
  end

  // R9
  swreset_chk: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (flip_q == '0 && dbg_q == '0 && be_q == '0));
  // R1
  id_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rd_idx == IDX_W'(SLOT_ID)) |=> (s_rdata == ID_VALUE));
endmodule

// File: tb/test_pktmon_regbank.sv
`timescale 1ns/1ps
module test_pktmon_regbank;
  localparam int CW = 5;
  logic clk = 0, rst = 1, sw_reset = 0, pkt_in = 0, pkt_out = 0;
  logic [7:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = 0; logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp; logic [31:0] rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pktmon_regbank #(.ADDR_W(8), .CNT_W(CW)) i_pktmon_regbank (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .pkt_in_pulse(pkt_in), .pkt_out_pulse(pkt_out),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready));

  // behavioural model state
  logic [31:0] m_flip, m_dbg, m_be;
  int m_cnt [2]; bit m_ovf [2];
  logic [31:0] exp_q [$]; string tag_q [$];
  string cur_tag = "";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return 32'h0000DA03;
      8'h04: return 32'h00000001;
      8'h08: return ~m_flip;
      8'h0C: return {m_ovf[0], 31'(m_cnt[0])};
      8'h10: return {m_ovf[1], 31'(m_cnt[1])};
      8'h14: return m_dbg;
      8'h18: return m_be;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (s[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_flip = 0; m_dbg = 0; m_be = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
      exp_q.delete(); tag_q.delete();
    end else begin
      bit clr0, clr1;
      clr0 = 0; clr1 = 0;
      if (rvalid && rready) begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, rdata, e);
        check({t, " R11 rresp"}, {30'b0, rresp}, 32'h0);
      end
      if (arvalid && arready) begin
        exp_q.push_back(model_read(araddr)); tag_q.push_back(cur_tag);
        clr0 = (araddr == 8'h0C); clr1 = (araddr == 8'h10);
      end
      if (sw_reset) begin
        m_flip = 0; m_dbg = 0; m_be = 0;
        for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
      end else begin
        for (int i = 0; i < 2; i++) begin
          bit c, p;
          c = (i == 0) ? clr0 : clr1;
          p = (i == 0) ? pkt_in : pkt_out;
          if (c) begin m_cnt[i] = 0; m_ovf[i] = 0; end
          else if (p) begin
            if (m_cnt[i] == (1 << CW) - 1) begin m_cnt[i] = 0; m_ovf[i] = 1; end
            else m_cnt[i]++;
          end
        end
      end
    end
  end

  task automatic aw_send(input logic [7:0] a);
    bit hs;
    awaddr = a; awvalid = 1;
    do begin hs = awready; @(negedge clk); end while (!hs);
    awvalid = 0;
  endtask

  task automatic w_send(input logic [31:0] d, input logic [3:0] s);
    bit hs;
    wdata = d; wstrb = s; wvalid = 1;
    do begin hs = wready; @(negedge clk); end while (!hs);
    wvalid = 0;
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    bit hs;
    if (order == 0) fork aw_send(a); w_send(d, s); join
    else if (order == 1) begin
      aw_send(a);
      repeat (3) begin check("R10 no early bvalid (aw only)", {31'b0, bvalid}, 0); @(negedge clk); end
      w_send(d, s);
    end else begin
      w_send(d, s);
      repeat (3) begin check("R10 no early bvalid (w only)", {31'b0, bvalid}, 0); @(negedge clk); end
      aw_send(a);
    end
    bready = 1;
    do begin hs = bvalid; if (hs) check("R10 bresp", {30'b0, bresp}, 0); @(negedge clk); end while (!hs);
    bready = 0;
    case (a)
      8'h08: m_flip = merge(m_flip, d, s);
      8'h14: m_dbg = merge(m_dbg, d, s);
      8'h18: m_be = merge(m_be, d, s);
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [7:0] a, input string tag, input int hold, input bit with_pulse);
    bit hs; logic [31:0] first;
    cur_tag = tag; araddr = a; arvalid = 1;
    if (with_pulse) pkt_in = 1;
    do begin hs = arready; @(negedge clk); pkt_in = 0; end while (!hs);
    arvalid = 0;
    if (hold > 0) begin
      first = rdata;
      repeat (hold) begin
        check("R11 rvalid held", {31'b0, rvalid}, 1);
        check("R11 rdata stable", rdata, first);
        @(negedge clk);
      end
    end
    rready = 1;
    do begin hs = rvalid; @(negedge clk); end while (!hs);
    rready = 0;
  endtask

  task automatic pulses(input int n_in, input int n_out);
    for (int i = 0; i < ((n_in > n_out) ? n_in : n_out); i++) begin
      pkt_in = (i < n_in); pkt_out = (i < n_out);
      @(negedge clk);
    end
    pkt_in = 0; pkt_out = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check("R12 bvalid", {31'b0, bvalid}, 0);
    check("R12 rvalid", {31'b0, rvalid}, 0);
    check("R12 ready", {29'b0, awready, wready, arready}, 32'h7);
    // R1 R2
    do_read(8'h00, "R1 id", 0, 0);
    do_read(8'h04, "R2 version", 2, 0);
    do_write(8'h00, 32'h12345678, 4'hF, 0);
    do_write(8'h04, 32'hFFFFFFFF, 4'hF, 1);
    do_read(8'h00, "R1 id after write", 0, 0);
    do_read(8'h04, "R2 version after write", 0, 0);
    // R3 flip
    do_read(8'h08, "R3 flip reset", 0, 0);
    do_write(8'h08, 32'h12345678, 4'hF, 2);
    do_read(8'h08, "R3 flip inverse", 0, 0);
    do_write(8'h08, 32'h0000FFFF, 4'b0011, 0);
    do_read(8'h08, "R3 flip strobe", 3, 0);
    // R4 R5 counters
    pulses(3, 2);
    do_write(8'h0C, 32'h00000055, 4'hF, 0);
    do_read(8'h0C, "R4 in count", 0, 0);
    do_read(8'h10, "R4 out count", 0, 0);
    do_read(8'h0C, "R5 in cleared", 0, 0);
    pulses(2, 0);
    do_read(8'h0C, "R5 clear wins over pulse", 0, 1);
    do_read(8'h0C, "R5 pulse during clear dropped", 0, 0);
    // R6 overflow
    pulses(33, 32);
    do_read(8'h0C, "R6 in wrap sticky", 0, 0);
    pulses(0, 2);
    do_read(8'h10, "R6 out flag stays", 0, 0);
    do_read(8'h10, "R6 flag cleared by read", 0, 0);
    // R7 debug
    do_write(8'h14, 32'hCAFEBABE, 4'hF, 1);
    do_write(8'h14, 32'h11223344, 4'b1010, 2);
    do_read(8'h14, "R7 debug strobes", 0, 0);
    // R8 big-endian
    do_write(8'h18, 32'hAABBCCDD, 4'hF, 0);
    do_read(8'h18, "R8 be full", 0, 0);
    do_write(8'h18, 32'h00000011, 4'b0001, 1);
    do_read(8'h18, "R8 be lane0", 0, 0);
    // R11 unmapped
    do_write(8'h1C, 32'hDEADBEEF, 4'hF, 0);
    do_read(8'h1C, "R11 unmapped", 0, 0);
    do_read(8'h40, "R11 unmapped high", 2, 0);
    // R9 software reset
    pulses(4, 1);
    sw_reset = 1; @(negedge clk); sw_reset = 0;
    do_read(8'h08, "R9 flip default", 0, 0);
    do_read(8'h0C, "R9 in default", 0, 0);
    do_read(8'h10, "R9 out default", 0, 0);
    do_read(8'h14, "R9 debug default", 0, 0);
    do_read(8'h18, "R9 be default", 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule